// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Read Latency

This block is a true two-port memory. Either port can read or write any word in any cycle, independently of the other port. Every address, control and write-data input is captured on the rising clock edge. The word is split into two byte lanes: bits 0–8 form the low lane and bits 9–17 form the high lane. Each lane has its own active-low enable, which gates writes and gates output drive.

Each port has a latency select input. When it is low, the port runs in the short path: read data leaves the memory register and is presented in the cycle right after the sampling edge. When it is high, one more output register is inserted, so data and output state appear one edge later.

A port is selected only when its active-low enable is low and its active-high enable is high. The output enable is asynchronous. Pad tri-stating is modelled by a per-lane drive flag; a lane whose flag is low reads as zero. The default depth is 1024 words. Setting `ADDR_W` to 13 gives the full 8K-word array.

Top module: `dual_port_lat_ram`

## Requirements
- R1: A port is selected on an edge only if `*_en_n_i` is 0 and `*_en_i` is 1 at that edge. In short-latency mode, an unselected edge leaves both drive flags at 0 for the following cycle.
- R2: In short-latency mode (`*_pipe_i`=0), a selected read at edge k presents the addressed word, with the selected lanes driving, from edge k until edge k+1.
- R3: In long-latency mode (`*_pipe_i`=1), a selected read at edge k presents the word from edge k+1 until edge k+2. The cycle after edge k shows the result of the previous edge's controls.
- R4: `*_we_n_i`=0 on a selected edge writes the word. `*_we_n_i`=1 reads it. A write cycle leaves the drive flags at 0.
- R5: On a write, bit 0 of `*_lane_n_i` gates data bits 0–8 and bit 1 gates bits 9–17. A lane is stored only when its bit is 0; otherwise that lane keeps its old content.
- R6: Drive flag `*_drive_o[l]` is 1 only if the read controls of the access had lane bit l = 0 and `*_oe_n_i` is 0. Lanes that are not driven read as zero on `*_rdata_o`.
- R7: `*_oe_n_i`=1 clears both drive flags and zeroes the data at once, without waiting for a clock edge. Returning it to 0 restores the data at once.
- R8: In long-latency mode, deselection and reselection take effect one cycle late. After a deselected edge, the first selected read edge still shows no drive; the data appears after the next edge.
- R9: Both ports work concurrently. If one port writes a word on the same edge that the other port reads it, the read returns the old value. The new value is returned from the next edge on. Two writes to one word on one edge leave it undefined.
- R10: While `rst_ni` is low, both drive flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the control registers |
| a_en_n_i | input | 1 | Port A active-low enable |
| a_en_i | input | 1 | Port A active-high enable |
| a_we_n_i | input | 1 | Port A write strobe, 0 = write, 1 = read |
| a_lane_n_i | input | 2 | Port A active-low byte-lane enables |
| a_oe_n_i | input | 1 | Port A asynchronous active-low output enable |
| a_pipe_i | input | 1 | Port A latency select, 1 = extra output register |
| a_addr_i | input | ADDR_W | Port A word address |
| a_wdata_i | input | 2*LANE_W | Port A write data |
| a_rdata_o | output | 2*LANE_W | Port A read data, zero on undriven lanes |
| a_drive_o | output | 2 | Port A per-lane drive flags |
| b_en_n_i | input | 1 | Port B active-low enable |
| b_en_i | input | 1 | Port B active-high enable |
| b_we_n_i | input | 1 | Port B write strobe, 0 = write, 1 = read |
| b_lane_n_i | input | 2 | Port B active-low byte-lane enables |
| b_oe_n_i | input | 1 | Port B asynchronous active-low output enable |
| b_pipe_i | input | 1 | Port B latency select |
| b_addr_i | input | ADDR_W | Port B word address |
| b_wdata_i | input | 2*LANE_W | Port B write data |
| b_rdata_o | output | 2*LANE_W | Port B read data |
| b_drive_o | output | 2 | Port B per-lane drive flags |

## Verification
The properties assume that all inputs are settled around each rising edge. The long-latency property also assumes that the latency select stays high across the two edges it spans. The bench therefore changes every input only at the falling edge. It changes a port's latency select only across an idle cycle, and it never lets both ports write the same word on one edge, since that result is undefined. The output enable is the one input the bench moves in mid-cycle, and only to show its asynchronous effect.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int LANES = 2;
  localparam int PORTS = 2;

  typedef struct packed {
    logic             act;     // read access in flight
    logic [LANES-1:0] lane_n;  // lane enables of that access
  } rd_ctl_t;
endpackage

// File: rtl/dpr_store.sv
module dpr_store
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic                               clk_i,
  input  logic [PORTS-1:0]                   wr_en_i,
  input  logic [PORTS-1:0][LANES-1:0]        lane_n_i,
  input  logic [PORTS-1:0][ADDR_W-1:0]       addr_i,
  input  logic [PORTS-1:0][LANES*LANE_W-1:0] wdata_i,
  output logic [PORTS-1:0][LANES*LANE_W-1:0] rdata_o
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  // Non-blocking read before write: a same-edge write from the other port is not seen.
  always_ff @(posedge clk_i) begin
    for (int p = 0; p < PORTS; p++) begin
      rdata_o[p] <= mem[addr_i[p]];
      if (wr_en_i[p]) begin
        for (int l = 0; l < LANES; l++) begin
          if (!lane_n_i[p][l]) mem[addr_i[p]][l*LANE_W +: LANE_W] <= wdata_i[p][l*LANE_W +: LANE_W];
        end
      end
    end
  end
endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage
  import dpr_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sel_i,
  input  logic                    we_n_i,
  input  logic [LANES-1:0]        lane_n_i,
  input  logic                    pipe_i,
  input  logic                    oe_n_i,
  input  logic [LANES*LANE_W-1:0] rd_word_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic [LANES-1:0]        drive_o
);
  localparam int DW = LANES * LANE_W;

  rd_ctl_t       ctl1_q, ctl2_q, cur;
  logic          mode_q;
  logic [DW-1:0] word2_q, word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl1_q  <= '{act: 1'b0, lane_n: '1};
      ctl2_q  <= '{act: 1'b0, lane_n: '1};
      mode_q  <= 1'b0;
      word2_q <= '0;
    end else begin
      ctl1_q.act    <= sel_i & we_n_i;
      ctl1_q.lane_n <= lane_n_i;
      mode_q        <= pipe_i;
      ctl2_q        <= ctl1_q;
      word2_q       <= rd_word_i;
    end
  end

  always_comb begin
    cur  = mode_q ? ctl2_q : ctl1_q;
    word = mode_q ? word2_q : rd_word_i;
    for (int l = 0; l < LANES; l++) begin
      drive_o[l] = cur.act & ~cur.lane_n[l] & ~oe_n_i;  // oe acts without a clock
      rdata_o[l*LANE_W +: LANE_W] = drive_o[l] ? word[l*LANE_W +: LANE_W] : '0;
    end
  end
endmodule

// File: rtl/dual_port_lat_ram.sv
module dual_port_lat_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    a_en_n_i,
  input  logic                    a_en_i,
  input  logic                    a_we_n_i,
  input  logic [LANES-1:0]        a_lane_n_i,
  input  logic                    a_oe_n_i,
  input  logic                    a_pipe_i,
  input  logic [ADDR_W-1:0]       a_addr_i,
  input  logic [LANES*LANE_W-1:0] a_wdata_i,
  output logic [LANES*LANE_W-1:0] a_rdata_o,
  output logic [LANES-1:0]        a_drive_o,
  input  logic                    b_en_n_i,
  input  logic                    b_en_i,
  input  logic                    b_we_n_i,
  input  logic [LANES-1:0]        b_lane_n_i,
  input  logic                    b_oe_n_i,
  input  logic                    b_pipe_i,
  input  logic [ADDR_W-1:0]       b_addr_i,
  input  logic [LANES*LANE_W-1:0] b_wdata_i,
  output logic [LANES*LANE_W-1:0] b_rdata_o,
  output logic [LANES-1:0]        b_drive_o
);
  localparam int DW = LANES * LANE_W;

  logic [PORTS-1:0]                 sel, we_n, oe_n, pipe, wr_en;
  logic [PORTS-1:0][LANES-1:0]      lane_n, drive;
  logic [PORTS-1:0][ADDR_W-1:0]     addr;
  logic [PORTS-1:0][DW-1:0]         wdata, rword, rdata;

  assign sel    = {~b_en_n_i & b_en_i, ~a_en_n_i & a_en_i};
  assign we_n   = {b_we_n_i, a_we_n_i};
  assign oe_n   = {b_oe_n_i, a_oe_n_i};
  assign pipe   = {b_pipe_i, a_pipe_i};
  assign lane_n = {b_lane_n_i, a_lane_n_i};
  assign addr   = {b_addr_i, a_addr_i};
  assign wdata  = {b_wdata_i, a_wdata_i};
  assign wr_en  = sel & ~we_n;

  dpr_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_store (
    .clk_i    (clk_i),
    .wr_en_i  (wr_en),
    .lane_n_i (lane_n),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rword)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    dpr_out_stage #(.LANE_W(LANE_W)) u_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_i     (sel[p]),
      .we_n_i    (we_n[p]),
      .lane_n_i  (lane_n[p]),
      .pipe_i    (pipe[p]),
      .oe_n_i    (oe_n[p]),
      .rd_word_i (rword[p]),
      .rdata_o   (rdata[p]),
      .drive_o   (drive[p])
    );
  end

  assign a_rdata_o = rdata[0];
  assign a_drive_o = drive[0];
  assign b_rdata_o = rdata[1];
  assign b_drive_o = drive[1];
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    a_en_n_i,
  input logic                    a_en_i,
  input logic                    a_we_n_i,
  input logic [LANES-1:0]        a_lane_n_i,
  input logic                    a_oe_n_i,
  input logic                    a_pipe_i,
  input logic [ADDR_W-1:0]       a_addr_i,
  input logic [LANES*LANE_W-1:0] a_wdata_i,
  input logic [LANES*LANE_W-1:0] a_rdata_o,
  input logic [LANES-1:0]        a_drive_o,
  input logic                    b_en_n_i,
  input logic                    b_en_i,
  input logic                    b_we_n_i,
  input logic [LANES-1:0]        b_lane_n_i,
  input logic                    b_oe_n_i,
  input logic                    b_pipe_i,
  input logic [ADDR_W-1:0]       b_addr_i,
  input logic [LANES*LANE_W-1:0] b_wdata_i,
  input logic [LANES*LANE_W-1:0] b_rdata_o,
  input logic [LANES-1:0]        b_drive_o
);
  logic sel_a;
  assign sel_a = ~a_en_n_i & a_en_i;

  a_r1_desel_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_a && !a_pipe_i) |=> (a_drive_o == '0));

  a_r2_short_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a && a_we_n_i && !a_pipe_i && a_lane_n_i == '0) ##1 !a_oe_n_i |-> (a_drive_o == '1));

  a_r4_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a && !a_we_n_i && !a_pipe_i) |=> (a_drive_o == '0));

  a_r7_oe_off_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_oe_n_i |-> (a_drive_o == '0 && a_rdata_o == '0));

  a_r7_oe_off_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_oe_n_i |-> (b_drive_o == '0 && b_rdata_o == '0));

  a_r8_desel_long: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_a && a_pipe_i) ##1 a_pipe_i |=> (a_drive_o == '0));
endmodule

bind dual_port_lat_ram dpr_checker #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) chk_i (.*);

// File: tb/dual_port_lat_ram_tb_top.sv
module dual_port_lat_ram_tb_top;
  localparam int CLK_P = 10;
  localparam int AW    = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_en_n, a_en, a_we_n, a_oe_n, a_pipe;
  logic        b_en_n, b_en, b_we_n, b_oe_n, b_pipe;
  logic [1:0]  a_ln, b_ln, a_drv, b_drv;
  logic [AW-1:0] a_ad, b_ad;
  logic [17:0] a_wd, b_wd, a_rd, b_rd;
  logic [17:0] mdl [1 << AW];
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P / 2) clk = ~clk;

  dual_port_lat_ram #(.ADDR_W(AW), .LANE_W(9)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .a_en_n_i(a_en_n), .a_en_i(a_en), .a_we_n_i(a_we_n), .a_lane_n_i(a_ln),
    .a_oe_n_i(a_oe_n), .a_pipe_i(a_pipe), .a_addr_i(a_ad), .a_wdata_i(a_wd),
    .a_rdata_o(a_rd), .a_drive_o(a_drv),
    .b_en_n_i(b_en_n), .b_en_i(b_en), .b_we_n_i(b_we_n), .b_lane_n_i(b_ln),
    .b_oe_n_i(b_oe_n), .b_pipe_i(b_pipe), .b_addr_i(b_ad), .b_wdata_i(b_wd),
    .b_rdata_o(b_rd), .b_drive_o(b_drv)
  );

  function automatic logic [17:0] pat(int ad, int s);
    return 18'((ad * 773 + s * 4099 + 5) ^ (ad << 7));
  endfunction

  function automatic logic [17:0] merge(logic [17:0] old_w, logic [17:0] new_w, logic [1:0] ln);
    logic [17:0] r = old_w;
    if (!ln[0]) r[8:0]  = new_w[8:0];
    if (!ln[1]) r[17:9] = new_w[17:9];
    return r;
  endfunction

  function automatic logic [17:0] lane_mask(logic [1:0] ln);
    return {{9{~ln[1]}}, {9{~ln[0]}}};
  endfunction

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_a(logic sel, logic we_n, logic [1:0] ln, int ad, logic [17:0] wd);
    a_en_n = ~sel; a_en = sel; a_we_n = we_n; a_ln = ln; a_ad = AW'(ad); a_wd = wd;
  endtask

  task automatic set_b(logic sel, logic we_n, logic [1:0] ln, int ad, logic [17:0] wd);
    b_en_n = ~sel; b_en = sel; b_we_n = we_n; b_ln = ln; b_ad = AW'(ad); b_wd = wd;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    set_a(0, 1, 2'b00, 0, '0); set_b(0, 1, 2'b00, 0, '0);
    a_oe_n = 0; b_oe_n = 0; a_pipe = 0; b_pipe = 0;
    repeat (3) tick();
    chk("R10 reset drive a", 18'(a_drv), 0);
    chk("R10 reset drive b", 18'(b_drv), 0);
    rst_n = 1'b1;
    tick();

    // Fill: A writes 0..63, B writes 64..127 concurrently
    for (int i = 0; i < 64; i++) begin
      set_a(1, 0, 2'b00, i, pat(i, 1));
      set_b(1, 0, 2'b00, i + 64, pat(i + 64, 1));
      mdl[i] = pat(i, 1); mdl[i + 64] = pat(i + 64, 1);
      tick();
      chk("R4 write leaves a undriven", 18'(a_drv), 0);
    end

    // Short-latency reads on both ports
    for (int i = 0; i < 128; i++) begin
      set_a(1, 1, 2'b00, i, '0);
      set_b(1, 1, 2'b00, 127 - i, '0);
      tick();
      chk("R2 short read a", a_rd, mdl[i]);
      chk("R2 short drive a", 18'(a_drv), 3);
      chk("R9 concurrent read b", b_rd, mdl[127 - i]);
    end
    set_a(0, 1, 2'b00, 0, '0);

    // Long latency on B, mode changed across an idle cycle
    set_b(0, 1, 2'b00, 0, '0); b_pipe = 1; tick();
    for (int i = 0; i < 32; i++) begin
      set_b(1, 1, 2'b00, i, '0);
      tick();
      if (i == 0) chk("R3 first long cycle undriven", 18'(b_drv), 0);
      else        chk("R3 long read b", b_rd, mdl[i - 1]);
    end
    set_b(0, 1, 2'b00, 0, '0); tick();
    chk("R8 output follows previous controls", b_rd, mdl[31]);
    tick();
    chk("R8 deselect one cycle late", 18'(b_drv), 0);
    set_b(1, 1, 2'b00, 5, '0); tick();
    chk("R8 reselect still undriven", 18'(b_drv), 0);
    set_b(1, 1, 2'b00, 6, '0); tick();
    chk("R8 reselect data", b_rd, mdl[5]);
    chk("R8 reselect drive", 18'(b_drv), 3);
    set_b(0, 1, 2'b00, 0, '0); tick(); tick();

    // Byte-lane writes, all four lane combinations
    for (int c = 0; c < 4; c++) begin
      mdl[200 + c] = pat(200 + c, 7);
      set_a(1, 0, 2'b00, 200 + c, pat(200 + c, 7)); tick();
      set_a(1, 0, 2'(c), 200 + c, pat(200 + c, 2));
      mdl[200 + c] = merge(mdl[200 + c], pat(200 + c, 2), 2'(c));
      tick();
    end
    for (int c = 0; c < 4; c++) begin
      set_a(1, 1, 2'b00, 200 + c, '0); tick();
      chk("R5 lane write merge", a_rd, mdl[200 + c]);
    end
    for (int c = 0; c < 4; c++) begin
      set_a(1, 1, 2'(c), 10, '0); tick();
      chk("R6 lane drive flags", 18'(a_drv), 18'(~c & 3));
      chk("R6 lane masked data", a_rd, mdl[10] & lane_mask(2'(c)));
    end

    // Asynchronous output enable
    set_a(1, 1, 2'b00, 11, '0); tick();
    chk("R7 oe low drives", 18'(a_drv), 3);
    #2 a_oe_n = 1'b1;
    #1 chk("R7 oe high drops drive", 18'(a_drv), 0);
    chk("R7 oe high zero data", a_rd, 0);
    a_oe_n = 1'b0;
    #1 chk("R7 oe low restores data", a_rd, mdl[11]);
    tick();

    // Same-edge write on A, read on B
    b_pipe = 0; set_b(0, 1, 2'b00, 0, '0); tick();
    set_a(1, 0, 2'b00, 20, pat(20, 3));
    set_b(1, 1, 2'b00, 20, '0);
    tick();
    chk("R9 same-edge read old", b_rd, mdl[20]);
    mdl[20] = pat(20, 3);
    set_a(0, 1, 2'b00, 0, '0);
    tick();
    chk("R9 next-edge read new", b_rd, mdl[20]);

    // Enable decoding in short-latency mode
    a_en_n = 1; a_en = 1; a_we_n = 1; a_ln = 0; a_ad = AW'(11); tick();
    chk("R1 active-low enable high deselects", 18'(a_drv), 0);
    a_en_n = 0; a_en = 0; tick();
    chk("R1 active-high enable low deselects", 18'(a_drv), 0);
    a_en_n = 0; a_en = 1; tick();
    chk("R1 both enables select", a_rd, mdl[11]);

    summary();
    $finish;
  end
endmodule